// File: doc/BRIEF.md
# Time-Multiplexed Symmetric Complex Pulse Compressor

This block applies a complex matched filter to a stream of complex radar echo samples. For every accepted input sample it produces one compressed output sample, the complex convolution of the most recent `NTAP = 2*NMUX*NUNIT` input samples with a symmetric complex coefficient set. Symmetry is exploited: the two samples that share a coefficient are summed first, and only the sum is multiplied. This halves the multiplies.

The multiplies are shared in time. The pre-added pairs are split into `NUNIT` groups of `NMUX` pairs. Each group owns one multiplier datapath, one pair selector and one coefficient selector. The group steps through its pairs over several fast clock cycles. It accumulates the products and latches its partial sum after the last product. The partial sums of all groups are then added and registered at the output. The fast clock stands in for the multiple of the sample rate. The pace of the input handshake stands in for the sample rate itself. The parameter `LANES` chooses how a complex product is formed. With `LANES=1` there are four real multipliers per group, and a pair takes one cycle. With `LANES=0` a single real multiplier per group does four multiplies in sequence, and a pair takes four cycles.

Both data sides are valid/ready streams. The input is accepted on a cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low while a sample is being computed. It also stays low while a finished result is waiting and `out_ready` is low. A result waits in the output register, unchanged, until it is taken. The coefficients are static inputs and may only change while the block is idle.

Top module: `pulse_compressor_tdm`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the sample history holds zeros.
- R2: Let x[0] be the sample accepted last and x[i] the one accepted i samples earlier. Let h[j] be the complex coefficient at `coef_re/coef_im[j*CW +: CW]` for j < NPAIR, used for both tap j and tap NTAP-1-j. Each output equals the sum over i of h(i)·x[i] as a complex product, exact in two's complement at width AW = DW+CW+1+clog2(NTAP).
- R3: `in_ready` is 0 in the cycle after an accepted sample, and it stays 0 until that sample's result has been produced.
- R4: `out_valid` rises exactly STEPS+1 clock edges after the accepting edge. STEPS is NMUX when `LANES=1` and 4·NMUX when `LANES=0`.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_re` and `out_im` hold their values and `in_ready` stays 0.
- R6: Each accepted sample yields exactly one result. `out_valid` falls after the handshake edge unless a new result is loaded.
- R7: With `LANES=0` the outputs are identical to those with `LANES=1`, with only the latency changed.
- R8: Input presented while `in_ready` is 0 is ignored: it never enters the history, so later outputs are unaffected.
- R9: Full-scale inputs and coefficients (DW and CW bit extremes) over a full history produce the exact result without overflow.
- R10: Until NTAP samples have been accepted after reset, the taps not yet filled contribute zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (multiple of sample rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_re | input | DW | Input sample, real part, signed |
| in_im | input | DW | Input sample, imaginary part, signed |
| coef_re | input | NPAIR*CW | Real parts of the half coefficient set, pair j at bits j*CW |
| coef_im | input | NPAIR*CW | Imaginary parts of the half coefficient set, pair j at bits j*CW |
| out_valid | output | 1 | Compressed sample available |
| out_ready | input | 1 | Downstream takes the sample this cycle |
| out_re | output | AW | Compressed output, real part, signed |
| out_im | output | AW | Compressed output, imaginary part, signed |

## Verification
A selector index that is off by one, or a coefficient taken from the wrong pair, gives a wrong value in the first output whose history reaches the affected tap. The same happens when the accumulator fails to clear or the mirrored tap is paired wrongly. Such a fault appears within NTAP samples of reset. A miscounted step counter changes the moment `out_valid` rises and leaves out or repeats a product, so the error shows on the very first result. A fault in the hand-off between accept and output shows as a stalled, lost or duplicated result, or as output data that changes under back-pressure. This is seen within one sample period.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
  // Phase of a complex product when one real multiplier is reused four times.
  typedef enum logic [1:0] {
    PH_RR = 2'd0,
    PH_II = 2'd1,
    PH_RI = 2'd2,
    PH_IR = 2'd3
  } mul_phase_e;
endpackage

// File: rtl/pcmp_delay_line.sv
module pcmp_delay_line #(
  parameter int DW    = 12,
  parameter int NPAIR = 8,
  localparam int NTAP = 2 * NPAIR,
  localparam int PW   = DW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_en,
  input  logic signed [DW-1:0]   din_re,
  input  logic signed [DW-1:0]   din_im,
  output logic [NPAIR*PW-1:0]    pre_re,
  output logic [NPAIR*PW-1:0]    pre_im
);
  logic signed [DW-1:0] tap_re [NTAP];
  logic signed [DW-1:0] tap_im [NTAP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAP; i++) begin
        tap_re[i] <= '0;
        tap_im[i] <= '0;
      end
    end else if (shift_en) begin
      tap_re[0] <= din_re;
      tap_im[0] <= din_im;
      for (int i = 1; i < NTAP; i++) begin
        tap_re[i] <= tap_re[i-1];
        tap_im[i] <= tap_im[i-1];
      end
    end
  end

  // Mirrored taps share a coefficient: add them before the multiplier.
  for (genvar j = 0; j < NPAIR; j++) begin : g_pre
    assign pre_re[j*PW +: PW] = {tap_re[j][DW-1], tap_re[j]}
                              + {tap_re[NTAP-1-j][DW-1], tap_re[NTAP-1-j]};
    assign pre_im[j*PW +: PW] = {tap_im[j][DW-1], tap_im[j]}
                              + {tap_im[NTAP-1-j][DW-1], tap_im[NTAP-1-j]};
  end
endmodule

// File: rtl/pcmp_sequencer.sv
module pcmp_sequencer
  import pcmp_pkg::*;
#(
  parameter int NMUX  = 4,
  parameter bit LANES = 1'b1,
  localparam int KW   = (NMUX > 1) ? $clog2(NMUX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [KW-1:0] k,
  output mul_phase_e    ph,
  output logic          first,
  output logic          last
);
  logic pair_done;

  assign pair_done = LANES ? 1'b1 : (ph == PH_IR);
  assign first     = (k == '0) && (ph == PH_RR);
  assign last      = pair_done && (k == KW'(NMUX - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      k    <= '0;
      ph   <= PH_RR;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        k    <= '0;
        ph   <= PH_RR;
      end
    end else if (last) begin
      busy <= 1'b0;
      k    <= '0;
      ph   <= PH_RR;
    end else if (pair_done) begin
      k    <= k + KW'(1);
      ph   <= PH_RR;
    end else begin
      ph   <= mul_phase_e'(ph + 2'd1);
    end
  end

  // R3: the top never starts a new sample while one is in flight
  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R4: the final step always ends the run on the next edge
  p_run_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last) |=> !busy);
endmodule

// File: rtl/pcmp_tap_unit.sv
module pcmp_tap_unit
  import pcmp_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CW    = 12,
  parameter int NMUX  = 4,
  parameter int NPAIR = 8,
  parameter int UIDX  = 0,
  parameter bit LANES = 1'b1,
  parameter int AW    = 29,
  localparam int KW   = (NMUX > 1) ? $clog2(NMUX) : 1,
  localparam int PW   = DW + 1,
  localparam int MW   = PW + CW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    busy,
  input  logic                    first,
  input  logic                    last,
  input  logic [KW-1:0]           k,
  input  mul_phase_e              ph,
  input  logic [NPAIR*PW-1:0]     pre_re,
  input  logic [NPAIR*PW-1:0]     pre_im,
  input  logic [NPAIR*CW-1:0]     coef_re,
  input  logic [NPAIR*CW-1:0]     coef_im,
  output logic signed [AW-1:0]    part_re,
  output logic signed [AW-1:0]    part_im
);
  logic signed [PW-1:0] d_re, d_im;
  logic signed [CW-1:0] h_re, h_im;
  logic signed [MW:0]   c_re, c_im;
  logic signed [AW-1:0] acc_re, acc_im, acc_nx_re, acc_nx_im;
  int                   sel;

  // Data selector and coefficient selector, driven by the same pair index.
  always_comb begin
    sel  = UIDX * NMUX + int'(k);
    d_re = pre_re[sel*PW +: PW];
    d_im = pre_im[sel*PW +: PW];
    h_re = coef_re[sel*CW +: CW];
    h_im = coef_im[sel*CW +: CW];
  end

  if (LANES) begin : g_lanes
    logic signed [MW-1:0] m_rr, m_ii, m_ri, m_ir;
    assign m_rr = d_re * h_re;
    assign m_ii = d_im * h_im;
    assign m_ri = d_re * h_im;
    assign m_ir = d_im * h_re;
    assign c_re = (ph == PH_RR) ? ({m_rr[MW-1], m_rr} - {m_ii[MW-1], m_ii}) : '0;
    assign c_im = (ph == PH_RR) ? ({m_ri[MW-1], m_ri} + {m_ir[MW-1], m_ir}) : '0;
  end else begin : g_serial
    logic signed [PW-1:0] op_a;
    logic signed [CW-1:0] op_b;
    logic signed [MW-1:0] m;
    assign op_a = (ph == PH_RR || ph == PH_RI) ? d_re : d_im;
    assign op_b = (ph == PH_RR || ph == PH_IR) ? h_re : h_im;
    assign m    = op_a * op_b;
    always_comb begin
      c_re = '0;
      c_im = '0;
      case (ph)
        PH_RR:   c_re = {m[MW-1], m};
        PH_II:   c_re = -{m[MW-1], m};
        default: c_im = {m[MW-1], m};
      endcase
    end
  end

  assign acc_nx_re = (first ? {AW{1'b0}} : acc_re) + AW'(c_re);
  assign acc_nx_im = (first ? {AW{1'b0}} : acc_im) + AW'(c_im);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_re  <= '0;
      acc_im  <= '0;
      part_re <= '0;
      part_im <= '0;
    end else if (busy) begin
      acc_re <= acc_nx_re;
      acc_im <= acc_nx_im;
      if (last) begin
        part_re <= acc_nx_re;
        part_im <= acc_nx_im;
      end
    end
  end

  // R2: the latched partial sum changes only on the last step of a run
  p_part_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && last) |=> ($stable(part_re) && $stable(part_im)));
endmodule

// File: rtl/pulse_compressor_tdm.sv
module pulse_compressor_tdm
  import pcmp_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CW    = 12,
  parameter int NMUX  = 4,
  parameter int NUNIT = 2,
  parameter bit LANES = 1'b1,
  localparam int NPAIR = NMUX * NUNIT,
  localparam int NTAP  = 2 * NPAIR,
  localparam int AW    = DW + CW + 1 + $clog2(NTAP),
  localparam int PW    = DW + 1,
  localparam int KW    = (NMUX > 1) ? $clog2(NMUX) : 1,
  localparam int STEPS = LANES ? NMUX : 4 * NMUX
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic [NPAIR*CW-1:0]  coef_re,
  input  logic [NPAIR*CW-1:0]  coef_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [AW-1:0] out_re,
  output logic signed [AW-1:0] out_im
);
  logic                 accept, busy, first, last, sum_pend;
  logic [KW-1:0]        k;
  mul_phase_e           ph;
  logic [NPAIR*PW-1:0]  pre_re, pre_im;
  logic signed [AW-1:0] part_re [NUNIT];
  logic signed [AW-1:0] part_im [NUNIT];
  logic signed [AW-1:0] total_re, total_im;

  // Output register is guaranteed free by the time this sample's sum lands.
  assign in_ready = !busy && !sum_pend && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  pcmp_delay_line #(.DW(DW), .NPAIR(NPAIR)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(accept),
    .din_re(in_re), .din_im(in_im),
    .pre_re(pre_re), .pre_im(pre_im)
  );

  pcmp_sequencer #(.NMUX(NMUX), .LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .busy(busy), .k(k), .ph(ph), .first(first), .last(last)
  );

  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    pcmp_tap_unit #(
      .DW(DW), .CW(CW), .NMUX(NMUX), .NPAIR(NPAIR),
      .UIDX(u), .LANES(LANES), .AW(AW)
    ) u_unit (
      .clk(clk), .rst_n(rst_n), .busy(busy), .first(first), .last(last),
      .k(k), .ph(ph), .pre_re(pre_re), .pre_im(pre_im),
      .coef_re(coef_re), .coef_im(coef_im),
      .part_re(part_re[u]), .part_im(part_im[u])
    );
  end

  always_comb begin
    total_re = '0;
    total_im = '0;
    for (int u = 0; u < NUNIT; u++) begin
      total_re = total_re + part_re[u];
      total_im = total_im + part_im[u];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_pend  <= 1'b0;
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      sum_pend <= busy && last;
      if (sum_pend) begin
        out_valid <= 1'b1;
        out_re    <= total_re;
        out_im    <= total_im;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // Latency watch: cycles since the last accepting edge.
  int unsigned lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                lat_cnt <= 0;
    else if (accept)           lat_cnt <= 1;
    else if (lat_cnt < 65535)  lat_cnt <= lat_cnt + 1;
  end

  // R3: an accepted sample closes the input on the next cycle
  p_accept_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R4: result appears a fixed number of edges after acceptance
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == STEPS + 2));
  // R5: a stalled result is held unchanged
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));
  // R6: a new sum never lands on an untaken result
  p_slot_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sum_pend |-> !out_valid);
endmodule

// File: tb/sim_pulse_compressor_tdm.sv
module sim_pulse_compressor_tdm;
  localparam int DW = 12, CW = 12, NMUX = 4, NUNIT = 2;
  localparam int NPAIR = NMUX * NUNIT;
  localparam int NTAP  = 2 * NPAIR;
  localparam int AW    = DW + CW + 1 + $clog2(NTAP);
  localparam int NVEC  = 20;
  localparam int VEC_RE [NVEC] = '{100, -37, 2047, -2048, 5, 0, 813, -1500, 64, -1,
                                   300, 1999, -777, 42, -2048, 1024, -9, 600, 0, 2047};
  localparam int VEC_IM [NVEC] = '{-50, 12, -2048, 2047, 0, 333, -91, 1400, -64, 1,
                                   -300, 7, 777, -42, -2048, -1024, 9, 0, 1500, 2047};

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, out_ready = 1'b1, sel = 1'b0;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  logic [NPAIR*CW-1:0]  coef_re, coef_im;
  logic rdy0, rdy1, ov0, ov1;
  logic signed [AW-1:0] ore0, oim0, ore1, oim1;
  logic rdy, ov;
  logic signed [AW-1:0] ore, oim;

  int n_chk = 0, n_fail = 0;
  longint hr [NTAP], hi [NTAP];
  int cr [NPAIR], ci [NPAIR];

  always #2 clk = ~clk;

  pulse_compressor_tdm #(.DW(DW), .CW(CW), .NMUX(NMUX), .NUNIT(NUNIT), .LANES(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid && !sel), .in_ready(rdy0),
    .in_re(in_re), .in_im(in_im), .coef_re(coef_re), .coef_im(coef_im),
    .out_valid(ov0), .out_ready(out_ready), .out_re(ore0), .out_im(oim0));

  pulse_compressor_tdm #(.DW(DW), .CW(CW), .NMUX(NMUX), .NUNIT(NUNIT), .LANES(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid && sel), .in_ready(rdy1),
    .in_re(in_re), .in_im(in_im), .coef_re(coef_re), .coef_im(coef_im),
    .out_valid(ov1), .out_ready(out_ready), .out_re(ore1), .out_im(oim1));

  assign rdy = sel ? rdy1 : rdy0;
  assign ov  = sel ? ov1  : ov0;
  assign ore = sel ? ore1 : ore0;
  assign oim = sel ? oim1 : oim0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic load_coefs(input bit full_scale);
    for (int j = 0; j < NPAIR; j++) begin
      cr[j] = full_scale ? -2048 : ((j * 37) % 200) - 100;
      ci[j] = full_scale ?  2047 : 50 - j * 13;
      coef_re[j*CW +: CW] = CW'(cr[j]);
      coef_im[j*CW +: CW] = CW'(ci[j]);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < NTAP; i++) begin hr[i] = 0; hi[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Offer one sample, follow it to the output and compare.
  task automatic send(input int re, input int im, input bit junk, input bit stall, input string req);
    int steps;
    longint er, ei;
    bit early;
    logic signed [AW-1:0] hold_re, hold_im;
    steps = sel ? 4 * NMUX : NMUX;
    while (!rdy) @(negedge clk);
    in_re = DW'(re); in_im = DW'(im); in_valid = 1'b1;
    if (stall) out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = NTAP - 1; i > 0; i--) begin hr[i] = hr[i-1]; hi[i] = hi[i-1]; end
    hr[0] = re; hi[0] = im;
    er = 0; ei = 0;
    for (int i = 0; i < NTAP; i++) begin
      int j;
      j = (i < NPAIR) ? i : NTAP - 1 - i;
      er += cr[j] * hr[i] - ci[j] * hi[i];
      ei += cr[j] * hi[i] + ci[j] * hr[i];
    end
    chk(rdy == 1'b0, "R3", longint'(rdy), 0);
    early = 1'b0;
    for (int c = 0; c <= steps; c++) begin
      if (ov) early = 1'b1;
      if (junk && c < steps) begin
        in_valid = 1'b1; in_re = DW'($urandom); in_im = DW'($urandom);
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(ov == 1'b1 && !early, "R4", longint'({early, ov}), 1);
    chk(longint'(ore) == er, req, longint'(ore), er);
    chk(longint'(oim) == ei, req, longint'(oim), ei);
    if (stall) begin
      hold_re = ore; hold_im = oim;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        chk(ov && rdy == 1'b0 && ore == hold_re && oim == hold_im, "R5",
            longint'(ore), longint'(hold_re));
      end
      out_ready = 1'b1;
    end
    @(negedge clk);
    chk(ov == 1'b0, "R6", longint'(ov), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    load_coefs(1'b0);
    do_reset();
    // R1: idle after reset on both variants
    chk(rdy0 == 1'b1, "R1", longint'(rdy0), 1);
    chk(ov0 == 1'b0,  "R1", longint'(ov0), 0);
    chk(rdy1 == 1'b1, "R1", longint'(rdy1), 1);
    chk(ov1 == 1'b0,  "R1", longint'(ov1), 0);

    // Table walk on the lane variant; early entries exercise R10 (zero history),
    // entry 5 drives junk while busy (R8), entry 9 stalls the output (R5).
    for (int v = 0; v < NVEC; v++)
      send(VEC_RE[v], VEC_IM[v], v == 5, v == 9,
           (v < NTAP - 1) ? ((v == 6) ? "R8" : "R10") : "R2");

    // R7: serial variant from a fresh reset, including junk and a stall
    do_reset();
    sel = 1'b1;
    for (int v = 0; v < 8; v++)
      send(VEC_RE[v+4], VEC_IM[v+4], v == 2, v == 5, "R7");
    sel = 1'b0;

    // R9: full-scale samples and coefficients over a full history
    load_coefs(1'b1);
    do_reset();
    for (int v = 0; v < NTAP + 1; v++)
      send(-2048, (v == NTAP) ? 2047 : -2048, 1'b0, 1'b0, "R9");

    report();
  end
endmodule